// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block runs one external machine cycle for an 8-bit processor with a 16-bit address space. The core supplies a request: a cycle kind, an address and, for writes, a data byte. The controller then sequences the pins through clock states T1 to T3, or T1 to T4 for an opcode fetch. The upper address byte sits on its own output lines for the whole cycle. The lower address byte shares eight bidirectional pins with the data. In T1 those pins carry the low address while the address-latch strobe is high, so that an external transparent latch can hold the byte once the pins move on to data.

The pins are modelled as a driven value `ad_o`, an output enable `ad_oe` and a sampled input `ad_i`. The shared strobe and status outputs are qualified by `bus_en`: when it is low, RD, WR and IO/M are treated as floating and INTA stays high. From the raw lines the block also derives separate active-low memory and I/O read and write strobes for simple glue-free decoding. Read data on the pins is captured on the clock edge that ends T3 and is handed back to the core with a one-cycle valid pulse.

Top module: `mcyc_bus_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 and `bus_en`, `ale` and `ad_oe` are 0. `rd_n`, `wr_n`, `inta_n` and all four decoded strobes are 1.
- R2: During every state of a cycle, {`io_m`,`s1`,`s0`} shows the kind's code and holds it. The kind codes and their status values are: opcode fetch (kind 0) 011, memory read (kind 1) 010, memory write (kind 2) 001, I/O read (kind 3) 110, I/O write (kind 4) 101, interrupt acknowledge (kind 5) 111.
- R3: `ale` is 1 only in T1, which is the cycle after a request is accepted. In T1 `ad_oe` is 1 and `ad_o` carries the low address byte.
- R4: `addr_hi` carries the high address byte from T1 to the last state of the cycle.
- R5: In T2 and T3, `rd_n` is low for kinds 0, 1 and 3, `wr_n` is low for kinds 2 and 4, and `inta_n` is low for kind 5. In every other state all three are high, and at most one of them is low at any time.
- R6: For kinds 2 and 4, `ad_oe` is 1 in T2 and T3 with `ad_o` equal to the write byte. For the other kinds `ad_oe` is 0 after T1.
- R7: For kinds 0, 1, 3 and 5, `ad_i` is sampled on the edge that ends T3. It appears on `rd_data` with `rd_valid` high for exactly the following cycle. Values on `ad_i` in T1 and T2 have no effect.
- R8: Kind 0 occupies four states and the other kinds three. `req_ready` returns to 1 in the cycle after the last state.
- R9: `mem_rd_n` is low exactly when `rd_n` is low with `io_m` 0, and `io_rd_n` when `rd_n` is low with `io_m` 1. `mem_wr_n` and `io_wr_n` follow the same rule using `wr_n`.
- R10: In T4 of an opcode fetch the strobes are inactive and `ad_oe` is 0. While idle, `bus_en` is 0.
- R11: A request raised while `req_ready` is 0 is ignored, and the running cycle continues unchanged.
- R12: Kind codes 6 and 7 are ignored: no cycle starts and `req_ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Cycle request |
| req_kind | input | 3 | Cycle kind code (see R2) |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Idle, so a request is accepted |
| addr_hi | output | 8 | Upper address lines |
| ad_o | output | 8 | Value driven on the shared address/data pins |
| ad_oe | output | 1 | Drive enable for the shared pins |
| ad_i | input | 8 | Value sampled from the shared pins |
| ale | output | 1 | Address-latch strobe |
| bus_en | output | 1 | Strobes and status driven (0 = floating) |
| io_m | output | 1 | Status: 1 = I/O space, 0 = memory space |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| inta_n | output | 1 | Interrupt acknowledge strobe, active low |
| mem_rd_n | output | 1 | Decoded memory read, active low |
| mem_wr_n | output | 1 | Decoded memory write, active low |
| io_rd_n | output | 1 | Decoded I/O read, active low |
| io_wr_n | output | 1 | Decoded I/O write, active low |
| rd_data | output | 8 | Captured read byte |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` is new |

## Verification
A wrong phase register shows at the pins in the same cycle it goes wrong. The latch strobe, the drive enable or a strobe changes where the cycle-by-cycle scoreboard does not expect it, and the cycle length and `req_ready` timing then shift by a state. A corrupted latched kind or address changes the status code or the upper address lines on the very next comparison. A read captured on the wrong edge only surfaces one cycle later, as a wrong `rd_data` value, because the bench drives the true byte on `ad_i` only during T3.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

    typedef enum logic [2:0] {
        K_FETCH = 3'd0,
        K_MRD   = 3'd1,
        K_MWR   = 3'd2,
        K_IORD  = 3'd3,
        K_IOWR  = 3'd4,
        K_INTA  = 3'd5
    } kind_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_T1,
        PH_T2,
        PH_T3,
        PH_T4
    } phase_e;

    function automatic logic kind_ok(input logic [2:0] code);
        return code < 3'd6;
    endfunction

    // {io_m, s1, s0} per kind
    function automatic logic [2:0] status_of(input kind_e k);
        case (k)
            K_FETCH: return 3'b011;
            K_MRD:   return 3'b010;
            K_MWR:   return 3'b001;
            K_IORD:  return 3'b110;
            K_IOWR:  return 3'b101;
            K_INTA:  return 3'b111;
            default: return 3'b000;
        endcase
    endfunction

    function automatic logic uses_rd(input kind_e k);
        return (k == K_FETCH) || (k == K_MRD) || (k == K_IORD);
    endfunction

    function automatic logic uses_wr(input kind_e k);
        return (k == K_MWR) || (k == K_IOWR);
    endfunction

    function automatic logic takes_data(input kind_e k);
        return uses_rd(k) || (k == K_INTA);
    endfunction

endpackage

// File: rtl/mcyc_seq.sv
module mcyc_seq
    import mcyc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] ad_i,
    output phase_e            phase,
    output kind_e             kind,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    typedef struct packed {
        phase_e            ph;
        kind_e             kind;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        case (st_q.ph)
            PH_IDLE: begin
                if (req_valid && kind_ok(req_kind)) begin
                    st_d.ph    = PH_T1;
                    st_d.kind  = kind_e'(req_kind);
                    st_d.addr  = req_addr;
                    st_d.wdata = req_wdata;
                end
            end
            PH_T1: st_d.ph = PH_T2;
            PH_T2: st_d.ph = PH_T3;
            PH_T3: begin
                if (takes_data(st_q.kind)) begin
                    st_d.rdata  = ad_i;
                    st_d.rvalid = 1'b1;
                end
                st_d.ph = (st_q.kind == K_FETCH) ? PH_T4 : PH_IDLE;
            end
            PH_T4:   st_d.ph = PH_IDLE;
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, kind: K_FETCH, addr: '0, wdata: '0,
                      rdata: '0, rvalid: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase  = st_q.ph;
    assign kind   = st_q.kind;
    assign addr   = st_q.addr;
    assign wdata  = st_q.wdata;
    assign rdata  = st_q.rdata;
    assign rvalid = st_q.rvalid;

endmodule

// File: rtl/mcyc_pin_drv.sv
module mcyc_pin_drv
    import mcyc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  phase_e            phase,
    input  kind_e             kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ready,
    output logic              bus_en,
    output logic              ale,
    output logic [2:0]        status,
    output logic [HI_W-1:0]   addr_hi,
    output logic [DATA_W-1:0] ad_o,
    output logic              ad_oe,
    output logic              rd_n,
    output logic              wr_n,
    output logic              inta_n
);

    logic strobe_win;

    always_comb begin
        ready      = (phase == PH_IDLE);
        bus_en     = !ready;
        ale        = (phase == PH_T1);
        strobe_win = (phase == PH_T2) || (phase == PH_T3);
        status     = bus_en ? status_of(kind) : 3'b000;
        addr_hi    = bus_en ? addr[ADDR_W-1:DATA_W] : '0;
        rd_n       = !(strobe_win && uses_rd(kind));
        wr_n       = !(strobe_win && uses_wr(kind));
        inta_n     = !(strobe_win && (kind == K_INTA));
        ad_oe      = ale || (strobe_win && uses_wr(kind));
        if (ale) begin
            ad_o = addr[DATA_W-1:0];
        end else if (ad_oe) begin
            ad_o = wdata;
        end else begin
            ad_o = '0;
        end
    end

endmodule

// File: rtl/mcyc_strobe_dec.sv
module mcyc_strobe_dec (
    input  logic bus_en,
    input  logic io_m,
    input  logic rd_n,
    input  logic wr_n,
    output logic mem_rd_n,
    output logic mem_wr_n,
    output logic io_rd_n,
    output logic io_wr_n
);

    localparam int SPACES = 2;

    logic [SPACES-1:0] rd_dec_n;
    logic [SPACES-1:0] wr_dec_n;

    // index 0: memory space, index 1: I/O space
    for (genvar g = 0; g < SPACES; g++) begin : g_space
        logic hit;
        assign hit         = bus_en && (io_m == (g == 1));
        assign rd_dec_n[g] = !(hit && !rd_n);
        assign wr_dec_n[g] = !(hit && !wr_n);
    end

    assign mem_rd_n = rd_dec_n[0];
    assign mem_wr_n = wr_dec_n[0];
    assign io_rd_n  = rd_dec_n[1];
    assign io_wr_n  = wr_dec_n[1];

endmodule

// File: rtl/mcyc_bus_ctrl.sv
module mcyc_bus_ctrl
    import mcyc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [HI_W-1:0]   addr_hi,
    output logic [DATA_W-1:0] ad_o,
    output logic              ad_oe,
    input  logic [DATA_W-1:0] ad_i,
    output logic              ale,
    output logic              bus_en,
    output logic              io_m,
    output logic              s1,
    output logic              s0,
    output logic              rd_n,
    output logic              wr_n,
    output logic              inta_n,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic              io_rd_n,
    output logic              io_wr_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    phase_e            phase;
    kind_e             kind;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic [2:0]        status;

    mcyc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ad_i      (ad_i),
        .phase     (phase),
        .kind      (kind),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rd_data),
        .rvalid    (rd_valid)
    );

    mcyc_pin_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .phase   (phase),
        .kind    (kind),
        .addr    (addr),
        .wdata   (wdata),
        .ready   (req_ready),
        .bus_en  (bus_en),
        .ale     (ale),
        .status  (status),
        .addr_hi (addr_hi),
        .ad_o    (ad_o),
        .ad_oe   (ad_oe),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .inta_n  (inta_n)
    );

    assign io_m = status[2];
    assign s1   = status[1];
    assign s0   = status[0];

    mcyc_strobe_dec u_dec (
        .bus_en   (bus_en),
        .io_m     (io_m),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .mem_rd_n (mem_rd_n),
        .mem_wr_n (mem_wr_n),
        .io_rd_n  (io_rd_n),
        .io_wr_n  (io_wr_n)
    );

endmodule

// File: rtl/mcyc_bus_chk.sv
module mcyc_bus_chk #(
    parameter int HI_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_ready,
    input logic [HI_W-1:0] addr_hi,
    input logic            ad_oe,
    input logic            ale,
    input logic            bus_en,
    input logic            io_m,
    input logic            s1,
    input logic            s0,
    input logic            rd_n,
    input logic            wr_n,
    input logic            inta_n,
    input logic            mem_rd_n,
    input logic            rd_valid
);

    // R3
    ale_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    // R3
    ale_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ale) |-> $past(req_ready));

    // R5
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!rd_n, !wr_n, !inta_n}) <= 1);

    // R10
    float_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |-> (rd_n && wr_n && inta_n && !ad_oe));

    // R9
    mem_rd_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_n |-> (!rd_n && !io_m && bus_en));

    // R4
    addr_hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !ale) |-> $stable(addr_hi));

    // R2
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !ale) |-> $stable({io_m, s1, s0}));

    // R6
    no_drive_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    // R7
    rvalid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(!rd_n || !inta_n));

endmodule

bind mcyc_bus_ctrl mcyc_bus_chk #(.HI_W(HI_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .addr_hi   (addr_hi),
    .ad_oe     (ad_oe),
    .ale       (ale),
    .bus_en    (bus_en),
    .io_m      (io_m),
    .s1        (s1),
    .s0        (s0),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .inta_n    (inta_n),
    .mem_rd_n  (mem_rd_n),
    .rd_valid  (rd_valid)
);

// File: tb/sim_mcyc_bus_ctrl.sv
`timescale 1ns/1ps
module sim_mcyc_bus_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = 3'd0;
    logic [15:0] req_addr = 16'h0;
    logic [7:0]  req_wdata = 8'h0;
    logic [7:0]  ad_i = 8'h0;
    logic        req_ready, ad_oe, ale, bus_en, io_m, s1, s0;
    logic        rd_n, wr_n, inta_n, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, rd_valid;
    logic [7:0]  addr_hi, ad_o, rd_data;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    mcyc_bus_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .addr_hi(addr_hi), .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i), .ale(ale),
        .bus_en(bus_en), .io_m(io_m), .s1(s1), .s0(s0), .rd_n(rd_n), .wr_n(wr_n),
        .inta_n(inta_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
        .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    typedef struct packed {
        logic       ready, bus_en, ale, ad_oe, rd_n, wr_n, inta_n;
        logic       mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, rvalid;
        logic [2:0] status;
        logic [7:0] hi, ad, rdata;
    } exp_t;

    exp_t q[$];

    task automatic chk(input string req, input string nm,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, nm, act, exp);
        end
    endtask

    function automatic logic [2:0] stat_code(input logic [2:0] k);
        case (k)
            3'd0: return 3'b011;
            3'd1: return 3'b010;
            3'd2: return 3'b001;
            3'd3: return 3'b110;
            3'd4: return 3'b101;
            default: return 3'b111;
        endcase
    endfunction

    // s: 0 = idle, 1..4 = T1..T4
    function automatic exp_t mk(input logic [2:0] k, input int s, input logic [15:0] a,
                                input logic [7:0] wd, input logic [7:0] rv, input bit valid);
        exp_t e;
        bit win = (s == 2) || (s == 3);
        bit is_rd = (k == 3'd0) || (k == 3'd1) || (k == 3'd3);
        bit is_wr = (k == 3'd2) || (k == 3'd4);
        e.ready    = (s == 0);
        e.bus_en   = (s != 0);
        e.ale      = (s == 1);
        e.status   = stat_code(k);
        e.hi       = a[15:8];
        e.ad_oe    = (s == 1) || (win && is_wr);
        e.ad       = (s == 1) ? a[7:0] : wd;
        e.rd_n     = !(win && is_rd);
        e.wr_n     = !(win && is_wr);
        e.inta_n   = !(win && k == 3'd5);
        e.mem_rd_n = !(win && is_rd && !e.status[2]);
        e.io_rd_n  = !(win && is_rd && e.status[2]);
        e.mem_wr_n = !(win && is_wr && !e.status[2]);
        e.io_wr_n  = !(win && is_wr && e.status[2]);
        e.rvalid   = valid;
        e.rdata    = rv;
        return e;
    endfunction

    // scoreboard monitor: one expected item per cycle while the queue is filled
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk("R8",  "req_ready", {7'd0, req_ready}, {7'd0, e.ready});
            chk("R10", "bus_en",    {7'd0, bus_en},    {7'd0, e.bus_en});
            chk("R3",  "ale",       {7'd0, ale},       {7'd0, e.ale});
            chk(e.ale ? "R3" : "R6", "ad_oe", {7'd0, ad_oe}, {7'd0, e.ad_oe});
            if (e.ad_oe) chk(e.ale ? "R3" : "R6", "ad_o", ad_o, e.ad);
            if (e.bus_en) begin
                chk("R2", "status", {5'd0, io_m, s1, s0}, {5'd0, e.status});
                chk("R4", "addr_hi", addr_hi, e.hi);
            end
            chk("R5", "rd/wr/inta", {5'd0, rd_n, wr_n, inta_n},
                {5'd0, e.rd_n, e.wr_n, e.inta_n});
            chk("R9", "decoded", {4'd0, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n},
                {4'd0, e.mem_rd_n, e.mem_wr_n, e.io_rd_n, e.io_wr_n});
            chk("R7", "rd_valid", {7'd0, rd_valid}, {7'd0, e.rvalid});
            if (e.rvalid) chk("R7", "rd_data", rd_data, e.rdata);
        end
    end

    // driver: one machine cycle; poke raises a second request mid-cycle (R11)
    task automatic run_cycle(input logic [2:0] k, input logic [15:0] a,
                             input logic [7:0] wd, input logic [7:0] rv, input bit poke);
        int n = (k == 3'd0) ? 4 : 3;
        bit takes = (k != 3'd2) && (k != 3'd4);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd; ad_i = ~rv;
        for (int s = 1; s <= n; s++) q.push_back(mk(k, s, a, wd, rv, takes && s == 4));
        q.push_back(mk(k, 0, a, wd, rv, takes && n == 3));
        for (int i = 1; i <= n + 1; i++) begin
            @(negedge clk);
            if (i == 1) req_valid = 1'b0;
            if (poke && i == 2) begin
                req_valid = 1'b1; req_kind = 3'd2; req_addr = 16'hDEAD; req_wdata = 8'h99;
            end
            if (poke && i == 3) req_valid = 1'b0;
            if (i == 3) ad_i = rv;   // only valid during T3 (R7)
            if (i == 4) ad_i = ~rv;
        end
    endtask

    // R12: reserved kind codes start nothing
    task automatic reserved_kind(input logic [2:0] k);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_addr = 16'h1234;
        q.push_back(mk(3'd0, 0, 16'h0, 8'h0, 8'h0, 1'b0));
        q.push_back(mk(3'd0, 0, 16'h0, 8'h0, 8'h0, 1'b0));
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 100000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "req_ready", {7'd0, req_ready}, 8'd1);
        chk("R1", "bus/ale/oe", {5'd0, bus_en, ale, ad_oe}, 8'd0);
        chk("R1", "strobes", {5'd0, rd_n, wr_n, inta_n}, 8'h07);
        chk("R1", "decoded", {4'd0, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}, 8'h0F);

        run_cycle(3'd0, 16'h2005, 8'h00, 8'h4F, 1'b0); // opcode fetch, R8 four states, R10 T4
        run_cycle(3'd1, 16'h2001, 8'h00, 8'h32, 1'b0); // memory read
        run_cycle(3'd2, 16'h80FF, 8'hA5, 8'h00, 1'b0); // memory write
        run_cycle(3'd3, 16'h0042, 8'h00, 8'h3C, 1'b0); // I/O read
        run_cycle(3'd4, 16'h0017, 8'h5A, 8'h00, 1'b0); // I/O write
        run_cycle(3'd5, 16'hFFFE, 8'h00, 8'hC7, 1'b0); // interrupt acknowledge
        run_cycle(3'd1, 16'h7F80, 8'h00, 8'hE1, 1'b1); // R11 request while busy
        reserved_kind(3'd6);                           // R12
        reserved_kind(3'd7);                           // R12
        run_cycle(3'd0, 16'h0000, 8'h00, 8'h00, 1'b0); // all-zero address and data
        run_cycle(3'd4, 16'hFFFF, 8'hFF, 8'h00, 1'b0); // all-ones write

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule